// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block counts system clock cycles and asks for a system reset when software fails to restart it in time. Software drives it through one byte-wide control write port. A restart byte clears the count. A byte with the top bit clear selects one of eight timeout lengths. A two-byte sequence, accepted only within a short window, switches the watchdog off. A lock byte keeps the watchdog on until the next system reset.

The block leaves reset already counting, with the longest interval selected. When the count since the last restart reaches the selected interval, the block raises a one-cycle reset request. Recording why a reset happened and stretching the reset are handled elsewhere. The block is reset by the same system reset it can request.

Top module: `wdog_timer`

## Requirements
- R1: After system reset `resetReq` is low, the watchdog is enabled and unlocked, and interval select 7 (the longest) is in force, so the first request comes L(7) cycles after reset is released.
- R2: A write of 0xA5 clears the count to zero and enables the watchdog. With no further writes, `resetReq` is high exactly L(sel) cycles after the edge that took the write.
- R3: A write with bit 7 clear loads sel = data[2:0], and bits 6:3 are ignored. The interval is L(sel) = 4^(BASE_EXP+sel) cycles, saturated at 2^CNT_W.
- R4: `resetReq` is high for exactly one cycle. The count restarts from zero on the edge that raised it, so the next request follows L(sel) cycles later.
- R5: A write of 0xDE followed by a write of 0xAD one to WIN_CYC (4) cycles later disables the watchdog. While disabled the count holds and no request is raised.
- R6: The disable sequence is cancelled in three cases: any other write comes between the two bytes, 0xAD arrives more than WIN_CYC cycles after 0xDE, or an expiry occurs in between. The watchdog then stays enabled.
- R7: A write of 0xFF locks the watchdog and enables it. While locked, the disable sequence has no effect. Only a system reset clears the lock.
- R8: A 0xA5 write on the same edge the count would expire takes priority. No request is raised on that edge.
- R9: If a new sel gives an interval shorter than the count already reached, the request is raised one cycle after the edge that took the sel write.
- R10: Enabling a disabled watchdog with 0xFF resumes counting from the held value, not from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset, asynchronous assert |
| ctlWrEn | input | 1 | Control write strobe, one byte per cycle |
| ctlWrData | input | 8 | Control write byte |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
Two functions can fall on the same edge: a restart write, and expiry of the count. The bench provokes this by writing 0xA5 exactly L cycles after an earlier restart. It passes only if no pulse appears after that edge and the next pulse arrives L cycles after the second write. A second collision is an expiry inside the disable window. The bench places 0xDE just before an expiry and 0xAD just after it, then checks that a request still arrives on the expected cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  localparam logic [7:0] CODE_RESTART = 8'hA5;
  localparam logic [7:0] CODE_ARM     = 8'hDE;
  localparam logic [7:0] CODE_CONFIRM = 8'hAD;
  localparam logic [7:0] CODE_LOCK    = 8'hFF;

  // Meaning of one control write.
  typedef enum logic [2:0] {
    W_RESTART,
    W_ARM,
    W_CONFIRM,
    W_LOCK,
    W_SEL,
    W_OTHER
  } wrKind_t;

  // Strobes from the control half to the counting half.
  typedef struct packed {
    logic run;
    logic clear;
  } dpCtl_t;

endpackage

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             expire,
  output dpCtl_t           strobe,
  output logic             enabled,
  output logic             locked,
  output logic [SEL_W-1:0] sel
);

  localparam int WIN_W = $clog2(WIN_CYC + 1);

  wrKind_t          kind;
  logic [WIN_W-1:0] winCnt;
  logic             armed;

  always_comb begin
    if (!wrData[7])                   kind = W_SEL;
    else if (wrData == CODE_RESTART)  kind = W_RESTART;
    else if (wrData == CODE_ARM)      kind = W_ARM;
    else if (wrData == CODE_CONFIRM)  kind = W_CONFIRM;
    else if (wrData == CODE_LOCK)     kind = W_LOCK;
    else                              kind = W_OTHER;
  end

  assign armed = (winCnt != '0);

  // Disable window: opened by the first byte, closed by any other write,
  // by expiry, or when it runs out.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (wrEn && kind == W_ARM) begin
      winCnt <= WIN_W'(WIN_CYC);
    end else if (wrEn || expire) begin
      winCnt <= '0;
    end else if (armed) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled <= 1'b1;
      locked  <= 1'b0;
      sel     <= '1;
    end else if (wrEn) begin
      case (kind)
        W_RESTART: enabled <= 1'b1;
        W_LOCK: begin
          locked  <= 1'b1;
          enabled <= 1'b1;
        end
        W_CONFIRM: if (armed && !locked) enabled <= 1'b0;
        W_SEL:     sel <= wrData[SEL_W-1:0];
        default:   ;
      endcase
    end
  end

  assign strobe.run   = enabled;
  assign strobe.clear = wrEn && (kind == W_RESTART);

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 21,
  parameter int BASE_EXP = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           strobe,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             resetReq
);

  logic [CNT_W-1:0] termTab [NUM_SEL];
  logic [CNT_W-1:0] term;

  // Terminal count per select: 4^(BASE_EXP+g) - 1, saturated to all ones.
  for (genvar g = 0; g < NUM_SEL; g++) begin : gTerm
    localparam int SH = 2 * (BASE_EXP + g);
    if (SH >= CNT_W) begin : gSat
      assign termTab[g] = '1;
    end else begin : gPow
      assign termTab[g] = {CNT_W{1'b1}} >> (CNT_W - SH);
    end
  end

  assign term = termTab[sel];
  assign hit  = strobe.run && !strobe.clear && (count >= term);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= hit;
      if (strobe.clear || hit) count <= '0;
      else if (strobe.run)     count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 21,
  parameter int BASE_EXP = 3,
  parameter int WIN_CYC  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  output logic       resetReq
);

  dpCtl_t           strobe;
  logic             enabled;
  logic             locked;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] count;
  logic             hit;

  wdog_ctl #(.WIN_CYC(WIN_CYC)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (ctlWrEn),
    .wrData  (ctlWrData),
    .expire  (hit),
    .strobe  (strobe),
    .enabled (enabled),
    .locked  (locked),
    .sel     (sel)
  );

  wdog_dp #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sel      (sel),
    .count    (count),
    .hit      (hit),
    .resetReq (resetReq)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWrEn,
  input logic [7:0]       ctlWrData,
  input logic             resetReq,
  input logic             enabled,
  input logic             locked,
  input logic [CNT_W-1:0] count
);

  logic restartWr;
  assign restartWr = ctlWrEn && (ctlWrData == 8'hA5);

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    restartWr |=> (count == '0) && !resetReq);  // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);  // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !restartWr) |=> (count == $past(count)));  // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> !resetReq);  // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);  // R7

  AST_LOCK_KEEPS_ON: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> enabled);  // R7

endmodule

bind wdog_timer wdog_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ctlWrEn   (ctlWrEn),
  .ctlWrData (ctlWrData),
  .resetReq  (resetReq),
  .enabled   (enabled),
  .locked    (locked),
  .count     (count)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

  localparam int CNT_W    = 12;
  localparam int BASE_EXP = 2;
  localparam int WIN_CYC  = 4;
  localparam int LMAX     = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = 8'h00;
  logic       resetReq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .WIN_CYC(WIN_CYC)) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .resetReq  (resetReq)
  );

  // {write byte, expected interval in cycles}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'd16},
    {8'h79, 16'd64},
    {8'h02, 16'd256},
    {8'h43, 16'd1024},
    {8'h04, 16'd4096},
    {8'h07, 16'd4096}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctlWrEn   = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn   = 1'b0;
    ctlWrData = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles until resetReq is seen, 0 if none within maxCyc.
  task automatic waitPulse(input int maxCyc, output int n);
    n = 0;
    for (int i = 1; i <= maxCyc; i++) begin
      @(negedge clk);
      if (resetReq) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic sysReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    check("R1 request low in reset", int'(resetReq), 0);
    sysReset();
    check("R1 request low after reset", int'(resetReq), 0);
    waitPulse(LMAX + 10, n);
    check("R1 default longest interval", n, LMAX);

    // Table walk: select, restart, measure interval and pulse width.
    for (int v = 0; v < 6; v++) begin
      wr(VEC[v][23:16]);
      wr(8'hA5);
      waitPulse(LMAX + 10, n);
      check("R2 R3 interval from restart", n, int'(VEC[v][15:0]));
      @(negedge clk);
      check("R4 single-cycle request", int'(resetReq), 0);
    end

    // R5: back-to-back disable, then re-enable.
    wr(8'h00);
    wr(8'hA5);
    wr(8'hDE);
    wr(8'hAD);
    waitPulse(300, n);
    check("R5 disabled, no request", n, 0);
    wr(8'hA5);
    waitPulse(40, n);
    check("R2 re-enable by restart", n, 16);

    // R5: second byte exactly WIN_CYC cycles after the first.
    wr(8'hA5);
    wr(8'hDE);
    idle(3);
    wr(8'hAD);
    waitPulse(100, n);
    check("R5 disable at window edge", n, 0);
    wr(8'hA5);

    // R6: second byte one cycle too late.
    wr(8'hA5);
    wr(8'hDE);
    idle(4);
    wr(8'hAD);
    waitPulse(40, n);
    check("R6 late confirm ignored", n, 10);

    // R6: another write in between.
    wr(8'hA5);
    wr(8'hDE);
    wr(8'h90);
    wr(8'hAD);
    waitPulse(40, n);
    check("R6 broken by other write", n, 13);

    // R6: expiry inside the window (R4 restart after expiry).
    wr(8'hA5);
    idle(13);
    wr(8'hDE);
    idle(2);
    wr(8'hAD);
    waitPulse(40, n);
    check("R6 broken by expiry", n, 15);

    // R8: restart on the expiry edge wins.
    wr(8'hA5);
    idle(15);
    wr(8'hA5);
    check("R8 no request on collision edge", int'(resetReq), 0);
    waitPulse(40, n);
    check("R8 interval from second restart", n, 16);

    // R9: shorter interval than count already reached.
    wr(8'h03);
    wr(8'hA5);
    idle(100);
    wr(8'h00);
    waitPulse(10, n);
    check("R9 immediate expiry", n, 1);

    // R10: lock from disabled resumes the held count.
    wr(8'hA5);
    idle(10);
    wr(8'hDE);
    wr(8'hAD);
    idle(20);
    wr(8'hFF);
    waitPulse(40, n);
    check("R10 resume from held count", n, 4);

    // R7: disable ignored while locked.
    wr(8'hA5);
    wr(8'hDE);
    wr(8'hAD);
    waitPulse(40, n);
    check("R7 locked ignores disable", n, 14);

    // R7: lock cleared by system reset.
    sysReset();
    wr(8'h00);
    wr(8'hDE);
    wr(8'hAD);
    waitPulse(100, n);
    check("R7 lock cleared by reset", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule